// File: doc/BRIEF.md
# Selectable Bit-Rate Tick Generator

This block produces the bit-rate timing for a serial transmitter and receiver. It runs from a system clock, and a reference-rate enable arrives on that clock at 1.8432 MHz. A 4-bit rate code picks one of ten standard baud rates. A 2-bit multiplier select scales that rate by 1, 16 or 64, to match the oversampling the serial engine was configured for. A runtime half-rate control halves the result.

The output is a single-cycle tick that both the transmit and receive sides use as their clock enable. Each rate is made by a phase accumulator. On every reference enable it adds `baud × multiplier` and wraps modulo the reference frequency, so the long-run average rate is exact. Halving is done by a toggle flop that flips on every base tick. Only every second base tick then reaches the output.

Top module: `bitrate_clkgen`

## Requirements
- R1: Rate codes 0 to 9 select 9600, 4800, 2400, 1800, 1200, 600, 300, 150, 110 and 75 baud in that order. The base tick rate is baud × multiplier × `ref_en` rate / 1843200.
- R2: `mult_sel` encodes the multiplier as follows: 2'b10 is x16, 2'b11 is x64, and 2'b00 or 2'b01 is x1. For example, code 0 gives a tick every 192 reference enables at x1, every 12 at x16 and every 3 at x64.
- R3: Rate codes 10 to 15 add nothing to the accumulator, and `bclk_tick` stays low.
- R4: With `half_rate` low, each accumulator wrap drives `bclk_tick` high for exactly one cycle. This is the cycle after the clock edge that samples the wrapping `ref_en`.
- R5: With `half_rate` high, the toggle flips on every wrap, and only wraps that find the toggle clear produce a tick. The toggle is held clear while `half_rate` is low, so the first wrap after `half_rate` rises produces a tick.
- R6: While `ref_en` is low, the accumulator holds its value and `bclk_tick` stays low in the following cycle.
- R7: `rst_n` low asynchronously clears the accumulator, the toggle and `bclk_tick`. The internal reset is released on the second rising clock edge after `rst_n` rises, and the first accumulation happens on the third edge.
- R8: The accumulator always stays below 1843200. Over one tick interval the period error against the nominal rate is at most one reference period; for example, 110 baud at x1 gives intervals of 16756 or 16757 enables.
- R9: `bclk_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference-rate enable, one cycle per 1.8432 MHz period |
| rate_code | input | 4 | Baud rate selector |
| mult_sel | input | 2 | Multiplier select (x1, x16, x64) |
| half_rate | input | 1 | Halve the output rate when high |
| bclk_tick | output | 1 | One-cycle bit-clock enable for transmit and receive |

## Verification
On every cycle, the assertions check four things: the accumulator stays below the modulus, ticks are never adjacent, an out-of-range rate code keeps the output silent, and a missing reference enable freezes the accumulator. The exact tick intervals for each code and multiplier can only be shown by the bench scenarios. The same holds for the every-other-wrap pattern of the half-rate toggle and its clean start, the cycle in which reset releases the first accumulation, and the bounded jitter of non-integer ratios such as 110 baud.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

  typedef enum logic [1:0] {
    MUL_X1     = 2'b00,
    MUL_X1_ALT = 2'b01,
    MUL_X16    = 2'b10,
    MUL_X64    = 2'b11
  } mult_sel_e;

  localparam int unsigned NUM_RATES = 10;

  // Nominal baud for each rate code; codes past the table give zero.
  function automatic int unsigned nominal_baud(input logic [3:0] code);
    int unsigned b;
    case (code)
      4'd0:    b = 9600;
      4'd1:    b = 4800;
      4'd2:    b = 2400;
      4'd3:    b = 1800;
      4'd4:    b = 1200;
      4'd5:    b = 600;
      4'd6:    b = 300;
      4'd7:    b = 150;
      4'd8:    b = 110;
      4'd9:    b = 75;
      default: b = 0;
    endcase
    return b;
  endfunction

  function automatic int unsigned mult_factor(input mult_sel_e m);
    int unsigned f;
    case (m)
      MUL_X16: f = 16;
      MUL_X64: f = 64;
      default: f = 1;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rate_step_sel.sv
module rate_step_sel
  import bitrate_pkg::*;
#(
  parameter int ACC_W = 22
) (
  input  logic [3:0]       rate_code,
  input  logic [1:0]       mult_sel,
  output logic [ACC_W-1:0] step
);

  logic [31:0] product;

  always_comb begin
    product = 32'(nominal_baud(rate_code) * mult_factor(mult_sel_e'(mult_sel)));
    step    = product[ACC_W-1:0];
  end

endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int REF_HZ = 1843200,
  parameter int ACC_W  = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap
);

  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(REF_HZ);

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    sum   = acc_q + step;
    wrap  = 1'b0;
    acc_d = acc_q;
    if (ref_en) begin
      if (sum >= MODULUS) begin
        wrap  = 1'b1;
        acc_d = sum - MODULUS;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/half_rate_div.sv
module half_rate_div (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic half_rate,
  output logic tick_q
);

  logic tog_q, tog_d;
  logic tick_d;

  always_comb begin
    tick_d = wrap & (~half_rate | ~tog_q);
    if (!half_rate)  tog_d = 1'b0;
    else if (wrap)   tog_d = ~tog_q;
    else             tog_d = tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tog_q  <= tog_d;
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/bitrate_clkgen.sv
module bitrate_clkgen #(
  parameter int REF_HZ = 1843200,
  localparam int ACC_W = $clog2(REF_HZ) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic [3:0] rate_code,
  input  logic [1:0] mult_sel,
  input  logic       half_rate,
  output logic       bclk_tick
);

  logic             rst_s1_q, rst_s2_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc_q;
  logic             wrap;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  rate_step_sel #(.ACC_W(ACC_W)) u_step (
    .rate_code (rate_code),
    .mult_sel  (mult_sel),
    .step      (step)
  );

  phase_accum #(.REF_HZ(REF_HZ), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .ref_en (ref_en),
    .step   (step),
    .acc_q  (acc_q),
    .wrap   (wrap)
  );

  half_rate_div u_half (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .wrap      (wrap),
    .half_rate (half_rate),
    .tick_q    (bclk_tick)
  );

endmodule

// File: rtl/bitrate_clkgen_chk.sv
module bitrate_clkgen_chk #(
  parameter int REF_HZ = 1843200,
  parameter int ACC_W  = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_en,
  input logic [3:0]       rate_code,
  input logic             bclk_tick,
  input logic [ACC_W-1:0] acc_q
);

  assert_acc_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(REF_HZ));

  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |=> !bclk_tick);

  assert_idle_code_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code >= 4'd10) |=> !bclk_tick);

  assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> (!bclk_tick && $stable(acc_q)));

endmodule

bind bitrate_clkgen bitrate_clkgen_chk #(.REF_HZ(REF_HZ), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_en    (ref_en),
  .rate_code (rate_code),
  .bclk_tick (bclk_tick),
  .acc_q     (acc_q)
);

// File: tb/bitrate_clkgen_bench.sv
module bitrate_clkgen_bench;

  localparam int REF = 1843200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_en;
  logic [3:0] rate_code;
  logic [1:0] mult_sel;
  logic       half_rate;
  logic       bclk_tick;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    cmp_en = 1'b0;
  string cur_req = "R4";

  // reference model state
  longint m_acc;
  bit     m_tog, exp_tick, rs1, rs2;

  always #5 clk = ~clk;

  bitrate_clkgen u_bitrate_clkgen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rate_code(rate_code),
    .mult_sel(mult_sel), .half_rate(half_rate), .bclk_tick(bclk_tick)
  );

  function automatic longint baud_of(input int code);
    case (code)
      0: return 9600;  1: return 4800; 2: return 2400; 3: return 1800;
      4: return 1200;  5: return 600;  6: return 300;  7: return 150;
      8: return 110;   9: return 75;
      default: return 0;
    endcase
  endfunction

  function automatic longint mult_of(input logic [1:0] m);
    if (m == 2'b10) return 16;
    if (m == 2'b11) return 64;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_tog = 0; exp_tick = 0; rs1 = 0; rs2 = 0;
    end else begin
      bit act, wr;
      longint s;
      act = rs2; rs2 = rs1; rs1 = 1;
      if (act) begin
        wr = 0;
        if (ref_en) begin
          s = m_acc + baud_of(int'(rate_code)) * mult_of(mult_sel);
          if (s >= REF) begin wr = 1; s = s - REF; end
          m_acc = s;
        end
        exp_tick = wr && (!half_rate || !m_tog);
        if (!half_rate) m_tog = 0;
        else if (wr)    m_tog = !m_tog;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done)
      chk(bclk_tick === exp_tick, cur_req, int'(bclk_tick), int'(exp_tick));
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (bclk_tick !== 1'b1);
  endtask

  // measure the interval between two ticks after skipping one
  task automatic interval(output int n);
    wait_tick();
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (bclk_tick !== 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, cnt;
    rst_n = 1'b0; ref_en = 1'b1; rate_code = 4'd0; mult_sel = 2'b10; half_rate = 1'b0;
    cycles(5);
    // R7: output low during reset
    chk(bclk_tick === 1'b0, "R7", int'(bclk_tick), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cur_req = "R7";
    cycles(20);

    // R4 and R1: 9600 x16 gives a tick every 12 enables
    cur_req = "R4";
    cycles(200);
    interval(n);
    chk(n == 12, "R1", n, 12);

    // R2: x64 and x1
    cur_req = "R2";
    mult_sel = 2'b11;
    interval(n);
    chk(n == 3, "R2", n, 3);
    mult_sel = 2'b00;
    interval(n);
    chk(n == 192, "R2", n, 192);
    mult_sel = 2'b01;
    interval(n);
    chk(n == 192, "R2", n, 192);

    // R5: halving at 9600 x16
    cur_req = "R5";
    mult_sel = 2'b10;
    cycles(30);
    half_rate = 1'b1;
    cycles(100);
    interval(n);
    chk(n == 24, "R5", n, 24);
    half_rate = 1'b0;
    cycles(37);
    half_rate = 1'b1;
    cycles(100);
    half_rate = 1'b0;

    // R6: sparse reference enable
    cur_req = "R6";
    mult_sel = 2'b11;
    for (int i = 0; i < 600; i++) begin
      ref_en = (i % 3 == 0);
      @(negedge clk);
    end
    ref_en = 1'b0;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (bclk_tick) cnt++; end
    chk(cnt == 0, "R6", cnt, 0);
    ref_en = 1'b1;

    // R3: out-of-range codes are silent
    cur_req = "R3";
    rate_code = 4'd12;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (bclk_tick) cnt++; end
    chk(cnt == 0, "R3", cnt, 0);
    rate_code = 4'd15;
    cnt = 0;
    for (int i = 0; i < 500; i++) begin @(negedge clk); if (bclk_tick) cnt++; end
    chk(cnt == 0, "R3", cnt, 0);

    // R1: other codes at x64
    cur_req = "R1";
    for (int c = 1; c < 10; c++) begin
      rate_code = 4'(c);
      cycles(400);
    end
    rate_code = 4'd4;
    interval(n);
    chk(n == 24, "R1", n, 24);

    // R8: non-integer ratio, 110 baud x1
    cur_req = "R8";
    rate_code = 4'd8;
    mult_sel = 2'b00;
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (bclk_tick !== 1'b1);
    chk(n == 16756 || n == 16757, "R8", n, 16756);

    // R9 and R7: x64 at 9600, then reset mid-run
    cur_req = "R9";
    rate_code = 4'd0;
    mult_sel = 2'b11;
    cycles(50);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bclk_tick === 1'b0, "R7", int'(bclk_tick), 0);
    cur_req = "R7";
    cycles(3);
    rst_n = 1'b1;
    cycles(40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule